// File: doc/BRIEF.md
# Edge-Interval Signal Qualifier

This block decides whether a demodulated serial stream comes from a real transmitter or is only noise, and it does so before any data is passed downstream. A start request opens a start-up delay. When the delay ends, the block times every gap between successive transitions of the input. It counts the gap in ticks of a clock-enable timebase and compares it with a programmable acceptance window that has a minimum and a maximum. A gap inside the window is a pass. A gap that is too short, or one that grows past the maximum, ends qualification at once and sends the block to sleep.

The number of passes needed is set by a 2-bit bit-count selector. Every bit is assumed to carry two transitions, so the selector asks for 0, 6, 12 or 18 passing gaps. Once enough consecutive gaps pass, the block enters the receive state and forwards the synchronized input to its data output. Sleep and receive are both terminal until the next start request. A 2-bit status output always shows the current phase.

Top module: `edge_window_qualifier`

## Requirements
- R1: After reset the status reads 00 (sleep) and the data output is low.
- R2: A start pulse moves the status to 01 (start-up) from any state. The block stays in start-up until `startup_len` ticks have elapsed. It then moves to 10 (checking), or straight to 11 (receive) when the bit-count selector is 0.
- R3: A gap is the number of tick-qualified cycles from one synchronized transition up to, but not including, the next. The first transition seen while checking only starts the timing and is not judged.
- R4: A gap with `win_lo` <= gap <= `win_hi` is a pass, and checking continues. Both limits count as inside the window.
- R5: A gap shorter than `win_lo` sends the block to sleep (00).
- R6: When the running count exceeds `win_hi` with no transition, the block goes to sleep without waiting for the next transition.
- R7: Selector values 1, 2 and 3 need 6, 12 and 18 consecutive passes before receive (11). With one pass still missing, the state remains 10.
- R8: With selector 0 the block enters receive directly after start-up, whatever the input does.
- R9: In receive, `dout` equals the input as seen through a two-flop synchronizer. In every other state `dout` is low.
- R10: Transitions of any spacing have no effect in sleep or in receive. Only a start pulse leaves those states.
- R11: The gap count advances only in cycles where `tick` is high, so the same clock spacing gives half the gap when `tick` is high on every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable for the gap and start-up counters |
| start | input | 1 | Start request, one-cycle pulse |
| din | input | 1 | Asynchronous demodulated input |
| win_lo | input | CNT_W | Minimum accepted gap, in ticks |
| win_hi | input | CNT_W | Maximum accepted gap, in ticks |
| startup_len | input | SU_W | Start-up delay, in ticks |
| bit_sel | input | 2 | Bit count: 0, 1, 2, 3 select 0, 3, 6, 9 bits |
| dout | output | 1 | Qualified data, low unless receiving |
| state_o | output | 2 | 00 sleep, 01 start-up, 10 checking, 11 receive |

## Verification
The hardest case to reach is the timeout path. There the block must give up while the input is silent, and it must do so on the exact tick after the count first exceeds the maximum. A second hard case is a run that stops one pass short of the target. The bench drives every selector value against every gap spacing from below the minimum to above the maximum. It then repeats selected spacings with `tick` high on every other cycle, so the same clock spacing lands on either side of the window.

// File: rtl/edge_qual_pkg.sv
package edge_qual_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'b00,
    ST_START = 2'b01,
    ST_CHECK = 2'b10,
    ST_RECV  = 2'b11
  } qual_state_e;

  // Two transitions per bit, three bits per selector step.
  function automatic logic [4:0] checks_needed(input logic [1:0] sel);
    return 5'(sel) * 5'd6;
  endfunction

  function automatic logic gap_in_window(input logic [15:0] gap,
                                         input logic [15:0] lo,
                                         input logic [15:0] hi);
    return (gap >= lo) && (gap <= hi);
  endfunction

endpackage

// File: rtl/eq_sync_edge.sv
module eq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic data_o,
  output logic edge_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], din};
  end

  assign data_o = sh_q[STAGES-1];
  assign edge_o = sh_q[STAGES-1] ^ sh_q[STAGES];

endmodule

// File: rtl/eq_interval_timer.sv
module eq_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart_i)                  cnt_q <= tick_i ? CNT_W'(1) : '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_restart_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q <= CNT_W'(1)));

  assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/eq_startup_timer.sv
module eq_startup_timer #(
  parameter int SU_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [SU_W-1:0] len_i,
  output logic            done_o
);
  logic [SU_W-1:0] cnt_q;

  assign done_o = (cnt_q >= len_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (clear_i)                    cnt_q <= '0;
    else if (run_i && tick_i && !done_o) cnt_q <= cnt_q + SU_W'(1);
  end

  assert_startup_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/eq_check_fsm.sv
module eq_check_fsm
  import edge_qual_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             su_done_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [1:0]       sel_i,
  output qual_state_e      state_o,
  output logic             su_clear_o,
  output logic             su_run_o
);
  qual_state_e state_q;
  logic        armed_q;
  logic [4:0]  pass_q;
  logic [4:0]  need;
  logic        judging;
  logic        ev_pass;
  logic        ev_short;
  logic        ev_long;
  logic        ev_fail;
  logic        ev_done;

  assign need     = checks_needed(sel_i);
  assign judging  = (state_q == ST_CHECK) && armed_q;
  assign ev_pass  = judging && edge_i && gap_in_window(16'(gap_i), 16'(lo_i), 16'(hi_i));
  assign ev_short = judging && edge_i && (gap_i < lo_i);
  assign ev_long  = judging && (gap_i > hi_i);
  assign ev_fail  = ev_short || ev_long;
  assign ev_done  = ev_pass && ((pass_q + 5'd1) == need);

  assign su_clear_o = start_i;
  assign su_run_o   = (state_q == ST_START);
  assign state_o    = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      armed_q <= 1'b0;
      pass_q  <= '0;
    end else if (start_i) begin
      state_q <= ST_START;
      armed_q <= 1'b0;
      pass_q  <= '0;
    end else begin
      case (state_q)
        ST_START: if (su_done_i) state_q <= (need == 5'd0) ? ST_RECV : ST_CHECK;
        ST_CHECK: begin
          if (ev_fail)       state_q <= ST_SLEEP;
          else if (ev_done)  state_q <= ST_RECV;
          else if (ev_pass)  pass_q  <= pass_q + 5'd1;
          if (edge_i && !armed_q) armed_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !start_i) |=> (state_q == ST_SLEEP));

  assert_recv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV && !start_i) |=> (state_q == ST_RECV));

  assert_fail_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fail && !start_i) |=> (state_q == ST_SLEEP));

  assert_pass_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |-> (pass_q < need));

  assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_START));

endmodule

// File: rtl/edge_window_qualifier.sv
module edge_window_qualifier
  import edge_qual_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SU_W      = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             din,
  input  logic [CNT_W-1:0] win_lo,
  input  logic [CNT_W-1:0] win_hi,
  input  logic [SU_W-1:0]  startup_len,
  input  logic [1:0]       bit_sel,
  output logic             dout,
  output logic [1:0]       state_o
);
  logic             din_sync;
  logic             din_edge;
  logic [CNT_W-1:0] gap_cnt;
  logic             su_done;
  logic             su_clear;
  logic             su_run;
  qual_state_e      state;

  eq_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din), .data_o(din_sync), .edge_o(din_edge)
  );

  eq_interval_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(din_edge), .cnt_o(gap_cnt)
  );

  eq_startup_timer #(.SU_W(SU_W)) u_su (
    .clk(clk), .rst_n(rst_n), .clear_i(su_clear), .run_i(su_run),
    .tick_i(tick), .len_i(startup_len), .done_o(su_done)
  );

  eq_check_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start), .su_done_i(su_done),
    .edge_i(din_edge), .gap_i(gap_cnt), .lo_i(win_lo), .hi_i(win_hi),
    .sel_i(bit_sel), .state_o(state), .su_clear_o(su_clear), .su_run_o(su_run)
  );

  assign dout    = (state == ST_RECV) ? din_sync : 1'b0;
  assign state_o = state;

  assert_dout_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b11) |-> (dout == 1'b0));

endmodule

// File: tb/edge_window_qualifier_tb_top.sv
module edge_window_qualifier_tb_top;
  localparam int LO = 4;
  localparam int HI = 8;
  localparam logic [1:0] S_SLEEP = 2'b00, S_START = 2'b01, S_CHECK = 2'b10, S_RECV = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       tick_div = 1'b0;
  logic       start = 1'b0;
  logic       din = 1'b0;
  logic [1:0] bit_sel = 2'd0;
  logic       dout;
  logic [1:0] state_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) tick <= tick_div ? ~tick : 1'b1;

  edge_window_qualifier dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .din(din),
    .win_lo(8'(LO)), .win_hi(8'(HI)), .startup_len(8'd5), .bit_sel(bit_sel),
    .dout(dout), .state_o(state_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Toggle din n times with clock spacing sp, then settle 4 cycles.
  task automatic drive_edges(input int n, input int sp);
    for (int i = 0; i < n; i++) begin
      din = ~din;
      if (i != n - 1) wait_cyc(sp);
    end
    wait_cyc(4);
  endtask

  function automatic int need_of(input int sel);
    return sel * 3 * 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    check(state_o == S_SLEEP, "R1 state", state_o, S_SLEEP);
    check(dout == 1'b0, "R1 dout", dout, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    // R10 edges in sleep ignored
    drive_edges(5, 5);
    check(state_o == S_SLEEP, "R10 sleep hold", state_o, S_SLEEP);
    check(dout == 1'b0, "R9 dout low in sleep", dout, 0);

    // Sweep: every selector against every spacing
    for (int sel = 0; sel < 4; sel++) begin
      for (int sp = 2; sp <= 10; sp++) begin
        bit pass_exp;
        bit_sel = 2'(sel);
        pulse_start();
        wait_cyc(2);
        check(state_o == S_START, "R2 start-up entered", state_o, S_START);
        wait_cyc(8);
        if (sel == 0) begin
          check(state_o == S_RECV, "R8 direct receive", state_o, S_RECV);
          pass_exp = 1'b1;
        end else begin
          check(state_o == S_CHECK, "R2 checking entered", state_o, S_CHECK);
          pass_exp = (sp >= LO) && (sp <= HI);
          if (pass_exp && sel == 1) begin
            drive_edges(need_of(sel), sp);
            check(state_o == S_CHECK, "R7 one pass short", state_o, S_CHECK);
            din = ~din;
            wait_cyc(4);
          end else begin
            drive_edges(need_of(sel) + 1, sp);
          end
          if (pass_exp)
            check(state_o == S_RECV, "R4 R7 window pass", state_o, S_RECV);
          else if (sp < LO)
            check(state_o == S_SLEEP, "R5 short gap", state_o, S_SLEEP);
          else
            check(state_o == S_SLEEP, "R6 long gap", state_o, S_SLEEP);
        end
        din = ~din;
        wait_cyc(3);
        if (pass_exp)
          check(dout == din, "R9 dout follows", dout, din);
        else
          check(dout == 1'b0, "R9 dout low", dout, 0);
        drive_edges(3, 2);
        check(state_o == (pass_exp ? S_RECV : S_SLEEP), "R10 terminal hold",
              state_o, pass_exp ? S_RECV : S_SLEEP);
      end
    end

    // R6 timeout while silent: one edge arms, then nothing
    bit_sel = 2'd1;
    pulse_start();
    wait_cyc(10);
    din = ~din;
    wait_cyc(HI);
    check(state_o == S_CHECK, "R6 before timeout", state_o, S_CHECK);
    wait_cyc(4);
    check(state_o == S_SLEEP, "R6 silent timeout", state_o, S_SLEEP);

    // R11 tick on every other cycle
    tick_div = 1'b1;
    pulse_start();
    wait_cyc(20);
    check(state_o == S_CHECK, "R11 slow start-up", state_o, S_CHECK);
    drive_edges(7, 12);
    check(state_o == S_RECV, "R11 12 cycles = 6 ticks pass", state_o, S_RECV);
    pulse_start();
    wait_cyc(20);
    drive_edges(7, 6);
    check(state_o == S_SLEEP, "R11 6 cycles = 3 ticks short", state_o, S_SLEEP);
    pulse_start();
    wait_cyc(20);
    drive_edges(7, 20);
    check(state_o == S_SLEEP, "R11 20 cycles = 10 ticks long", state_o, S_SLEEP);
    tick_div = 1'b0;

    // R2 restart from receive
    bit_sel = 2'd0;
    pulse_start();
    wait_cyc(10);
    check(state_o == S_RECV, "R2 R8 receive", state_o, S_RECV);
    pulse_start();
    wait_cyc(1);
    check(state_o == S_START, "R2 restart from receive", state_o, S_START);
    check(dout == 1'b0, "R9 dout low in start-up", dout, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule